// File: doc/BRIEF.md
# Congestion-Aware Multipath Egress Selector

This block picks an output port for every packet that a switch forwards to a group of equal-cost paths. Each packet arrives as a descriptor carrying a flow hash, a traffic class and a flag that marks it as safe for per-packet path choice. For flagged packets the block compares the queue depth of every member port, using only the queue of the packet's own traffic class, and sends the packet to the least loaded member. Packets without the flag keep a fixed port per flow, chosen by hashing, so that their order is preserved.

Members can lie on paths of unequal length. Each port carries a one-bit tag that marks it as lying on a shortest path. Shortest-path members are used while at least one of them sits below a programmable congestion threshold. Longer members are used only when every shortest-path member is at or above it, and if every member is congested the globally least loaded member wins. Equal loads are shared through a rotating pointer. The selector is fully pipelined: it accepts one descriptor per cycle and answers a fixed three cycles later.

Top module: `mpath_egress_sel`

## Requirements
- R1: For a flagged descriptor whose member ports all have the same tag, the chosen port is a member with the smallest load.
- R2: The load of port p for class c is the OCC_W-bit field at bit offset ((p*NCLASS)+c)*OCC_W of `occ_flat`; only the field of the descriptor's own class is compared, and the other classes have no effect on the choice.
- R3: For an unflagged descriptor the chosen port is the k-th set bit of the member mask counted from port 0 upward (k from 0), where k is the flow hash modulo the number of members; occupancy has no effect on it.
- R4: A port counts as shortest-path when its bit in `short_tag` is 1. If a shortest-path member has a load below `cong_thresh`, the flagged choice is the least loaded shortest-path member.
- R5: If every shortest-path member is at or above the threshold and a longer member is below it, the flagged choice is the least loaded longer member.
- R6: If every member is at or above the threshold the flagged choice is the least loaded member overall; when no member carries the shortest-path tag, all members form a single tier.
- R7: Among members that tie for the smallest load, the first one met going upward from the rotating pointer (wrapping past the top port) is chosen. The pointer resets to 0 and advances by one, modulo NPORTS, after every flagged descriptor that has at least one member.
- R8: A descriptor with an empty member mask yields `sel_valid` and `sel_drop` both high with `sel_port` equal to 0, and does not advance the pointer.
- R9: Each descriptor accepted in cycle c produces its result in cycle c+3; one descriptor may be accepted every cycle, and `sel_valid` is low in cycles with no result due.
- R10: While reset is held and after it is released, `sel_valid` is low until a result is due, and the pointer starts at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| desc_valid | input | 1 | Descriptor present this cycle |
| desc_hash | input | HASH_W | Flow hash of the packet header |
| desc_tc | input | $clog2(NCLASS) | Traffic class of the packet |
| desc_adaptive | input | 1 | Packet may take any member path |
| member_mask | input | NPORTS | Ports belonging to the path group |
| short_tag | input | NPORTS | 1 marks a port on a shortest path |
| cong_thresh | input | OCC_W | Load at or above which a port is congested |
| occ_flat | input | NPORTS*NCLASS*OCC_W | Queue occupancy per port and class |
| sel_valid | output | 1 | Result strobe |
| sel_port | output | $clog2(NPORTS) | Chosen egress port |
| sel_drop | output | 1 | No member: packet is to be dropped |

## Verification
Every result, whether a flagged choice, a hash choice or a drop, is due exactly three clock cycles after the descriptor is presented, and idle cycles must show no strobe. The bench keeps a three-entry line of expected results computed from a software model of the tiers, threshold, pointer and hash rule; at each falling edge it first compares the outputs with the entry presented three cycles earlier and then drives the next descriptor. Descriptors are issued back to back and with random gaps, so the pipeline is checked at full rate as well as when idle.

// File: rtl/mp_pkg.sv
// Shared types for the multipath egress selector.
// Assumes nothing beyond SystemVerilog 2017.
package mp_pkg;

    // Which group of member ports a flagged packet may choose from.
    typedef enum logic [1:0] {
        TIER_SHORT = 2'd0,   // uncongested shortest-path member exists
        TIER_LONG  = 2'd1,   // only longer members are uncongested
        TIER_ALL   = 2'd2    // everything congested: pick over all members
    } tier_e;

endpackage

// File: rtl/mp_class_load.sv
// Stage 1 of the selector: extracts the per-class load of every port,
// decides the candidate tier and builds one sortable key per port.
// Key = {not_candidate, load, distance from rotating pointer}, so the
// smallest key is the least loaded candidate nearest the pointer.
// Assumes NPORTS is a power of two so the distance wraps naturally.
module mp_class_load
    import mp_pkg::*;
#(
    parameter int NPORTS = 16,
    parameter int NCLASS = 8,
    parameter int OCC_W  = 16,
    localparam int IDX_W = $clog2(NPORTS),
    localparam int TC_W  = $clog2(NCLASS),
    localparam int KEY_W = 1 + OCC_W + IDX_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          desc_valid,
    input  logic                          desc_adaptive,
    input  logic [TC_W-1:0]               desc_tc,
    input  logic [NPORTS-1:0]             member_mask,
    input  logic [NPORTS-1:0]             short_tag,
    input  logic [OCC_W-1:0]              cong_thresh,
    input  logic [NPORTS*NCLASS*OCC_W-1:0] occ_flat,
    output logic [NPORTS*KEY_W-1:0]       key_flat,
    output logic [IDX_W-1:0]              ptr_s1
);

    logic [OCC_W-1:0]  load_c  [NPORTS];
    logic [NPORTS-1:0] below_c;
    logic [NPORTS-1:0] short_set;
    logic [NPORTS-1:0] long_set;
    logic [NPORTS-1:0] cand_c;
    tier_e             tier_c;
    logic [KEY_W-1:0]  key_c   [NPORTS];
    logic [KEY_W-1:0]  key_q   [NPORTS];
    logic [IDX_W-1:0]  ptr_q;
    logic              advance;

    // Pick the queue of the packet's class on every port and test it.
    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            load_c[p]  = occ_flat[(p*NCLASS + int'(desc_tc))*OCC_W +: OCC_W];
            below_c[p] = load_c[p] < cong_thresh;
        end
    end

    // Split members into tiers; untagged groups form one tier.
    always_comb begin
        short_set = member_mask & short_tag;
        long_set  = member_mask & ~short_tag;
        if (short_set == '0) begin
            short_set = member_mask;
            long_set  = '0;
        end
        if (|(short_set & below_c))
            tier_c = TIER_SHORT;
        else if (|(long_set & below_c))
            tier_c = TIER_LONG;
        else
            tier_c = TIER_ALL;
        case (tier_c)
            TIER_SHORT: cand_c = short_set;
            TIER_LONG:  cand_c = long_set;
            default:    cand_c = member_mask;
        endcase
    end

    // Build the per-port sort key relative to the rotating pointer.
    always_comb begin
        for (int p = 0; p < NPORTS; p++) begin
            key_c[p] = {~cand_c[p], load_c[p], IDX_W'(p) - ptr_q};
        end
    end

    assign advance = desc_valid && desc_adaptive && (|member_mask);

    // Register keys, capture the pointer used, and rotate it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int p = 0; p < NPORTS; p++) key_q[p] <= '1;
            ptr_q  <= '0;
            ptr_s1 <= '0;
        end else begin
            for (int p = 0; p < NPORTS; p++) key_q[p] <= key_c[p];
            ptr_s1 <= ptr_q;
            if (advance) ptr_q <= ptr_q + 1'b1;
        end
    end

    for (genvar gp = 0; gp < NPORTS; gp++) begin : g_out
        assign key_flat[gp*KEY_W +: KEY_W] = key_q[gp];
    end

    // R7: pointer moves by exactly one per flagged decision.
    a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        advance |=> ptr_q == $past(ptr_q) + 1'b1);

    // R8: an empty group never moves the pointer.
    a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && member_mask == '0) |=> $stable(ptr_q));

endmodule

// File: rtl/mp_argmin_stage.sv
// One registered level of the minimum-key comparator tree.
// Reduces N_IN keys to N_OUT keys, each the smallest of a group of
// N_IN/N_OUT consecutive inputs. Assumes N_IN is a multiple of N_OUT
// and that keys are unique, so no tie rule is needed here.
module mp_argmin_stage #(
    parameter int N_IN  = 16,
    parameter int N_OUT = 4,
    parameter int KEY_W = 21,
    localparam int GRP  = N_IN / N_OUT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_IN*KEY_W-1:0]  key_in,
    output logic [N_OUT*KEY_W-1:0] key_out
);

    for (genvar g = 0; g < N_OUT; g++) begin : g_grp
        logic [KEY_W-1:0] best_c;
        logic [KEY_W-1:0] best_q;

        // Find the smallest key of this group.
        always_comb begin
            best_c = key_in[g*GRP*KEY_W +: KEY_W];
            for (int j = 1; j < GRP; j++) begin
                if (key_in[(g*GRP + j)*KEY_W +: KEY_W] < best_c)
                    best_c = key_in[(g*GRP + j)*KEY_W +: KEY_W];
            end
        end

        // Hold the group winner for the next level.
        always_ff @(posedge clk) begin
            if (!rst_n) best_q <= '1;
            else        best_q <= best_c;
        end

        assign key_out[g*KEY_W +: KEY_W] = best_q;

        for (genvar j = 0; j < GRP; j++) begin : g_chk
            // R1: the registered winner never exceeds any key it saw.
            a_r1_group_min: assert property (@(posedge clk) disable iff (!rst_n)
                1'b1 |=> best_q <= $past(key_in[(g*GRP + j)*KEY_W +: KEY_W]));
        end
    end

endmodule

// File: rtl/mp_hash_pick.sv
// Static path for unflagged packets: the flow hash modulo the member
// count selects the k-th member in ascending port order. Three register
// stages so its result lines up with the adaptive tree.
// Assumes rem < member count <= NPORTS, so rem fits IDX_W bits.
module mp_hash_pick #(
    parameter int NPORTS = 16,
    parameter int HASH_W = 16,
    localparam int IDX_W = $clog2(NPORTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HASH_W-1:0] desc_hash,
    input  logic [NPORTS-1:0] member_mask,
    output logic [IDX_W-1:0]  pick_s3
);

    logic [IDX_W:0]    cnt_c;
    logic [IDX_W-1:0]  rem_c;
    logic [IDX_W-1:0]  rem_q;
    logic [NPORTS-1:0] mask_q;
    logic [IDX_W-1:0]  pick_c;
    logic [IDX_W-1:0]  pick_q;
    logic [IDX_W:0]    seen;

    // Count members and reduce the hash modulo that count.
    always_comb begin
        cnt_c = '0;
        for (int p = 0; p < NPORTS; p++) cnt_c = cnt_c + {{IDX_W{1'b0}}, member_mask[p]};
        rem_c = (cnt_c == '0) ? '0 : IDX_W'(desc_hash % HASH_W'(cnt_c));
    end

    // Walk the stored mask upward and stop at the rem-th member.
    always_comb begin
        pick_c = '0;
        seen   = '0;
        for (int p = 0; p < NPORTS; p++) begin
            if (mask_q[p]) begin
                if (seen == {1'b0, rem_q}) pick_c = IDX_W'(p);
                seen = seen + 1'b1;
            end
        end
    end

    // Pipeline registers for the three hash stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            mask_q  <= '0;
            pick_q  <= '0;
            pick_s3 <= '0;
        end else begin
            rem_q   <= rem_c;
            mask_q  <= member_mask;
            pick_q  <= pick_c;
            pick_s3 <= pick_q;
        end
    end

    // R3: a non-empty group always yields a remainder inside the group.
    a_r3_rem_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (member_mask != '0) |=> ({1'b0, rem_q} < $past(cnt_c)));

endmodule

// File: rtl/mpath_egress_sel.sv
// Top of the congestion-aware multipath egress selector.
// Stage 1 builds per-port keys, stages 2 and 3 reduce them through a
// two-level comparator tree; a parallel hash path serves unflagged
// packets. Fixed latency of three cycles, one descriptor per cycle.
// Assumes NPORTS is a power of two and a multiple of 4.
module mpath_egress_sel #(
    parameter int NPORTS = 16,
    parameter int NCLASS = 8,
    parameter int OCC_W  = 16,
    parameter int HASH_W = 16,
    localparam int IDX_W = $clog2(NPORTS),
    localparam int TC_W  = $clog2(NCLASS),
    localparam int KEY_W = 1 + OCC_W + IDX_W,
    localparam int MID_N = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           desc_valid,
    input  logic [HASH_W-1:0]              desc_hash,
    input  logic [TC_W-1:0]                desc_tc,
    input  logic                           desc_adaptive,
    input  logic [NPORTS-1:0]              member_mask,
    input  logic [NPORTS-1:0]              short_tag,
    input  logic [OCC_W-1:0]               cong_thresh,
    input  logic [NPORTS*NCLASS*OCC_W-1:0] occ_flat,
    output logic                           sel_valid,
    output logic [IDX_W-1:0]               sel_port,
    output logic                           sel_drop
);

    logic [NPORTS*KEY_W-1:0] key_s1;
    logic [MID_N*KEY_W-1:0]  key_s2;
    logic [KEY_W-1:0]        key_s3;
    logic [IDX_W-1:0]        ptr_s1;
    logic [IDX_W-1:0]        ptr_s2;
    logic [IDX_W-1:0]        ptr_s3;
    logic [IDX_W-1:0]        hash_s3;
    logic [2:0]              vld_q;
    logic [2:0]              adp_q;
    logic [2:0]              drp_q;
    logic                    unused_load;

    mp_class_load #(.NPORTS(NPORTS), .NCLASS(NCLASS), .OCC_W(OCC_W)) u_load (
        .clk          (clk),
        .rst_n        (rst_n),
        .desc_valid   (desc_valid),
        .desc_adaptive(desc_adaptive),
        .desc_tc      (desc_tc),
        .member_mask  (member_mask),
        .short_tag    (short_tag),
        .cong_thresh  (cong_thresh),
        .occ_flat     (occ_flat),
        .key_flat     (key_s1),
        .ptr_s1       (ptr_s1)
    );

    mp_argmin_stage #(.N_IN(NPORTS), .N_OUT(MID_N), .KEY_W(KEY_W)) u_tree_a (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_in (key_s1),
        .key_out(key_s2)
    );

    mp_argmin_stage #(.N_IN(MID_N), .N_OUT(1), .KEY_W(KEY_W)) u_tree_b (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_in (key_s2),
        .key_out(key_s3)
    );

    mp_hash_pick #(.NPORTS(NPORTS), .HASH_W(HASH_W)) u_hash (
        .clk        (clk),
        .rst_n      (rst_n),
        .desc_hash  (desc_hash),
        .member_mask(member_mask),
        .pick_s3    (hash_s3)
    );

    // Carry the descriptor's control bits alongside the data stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            adp_q  <= '0;
            drp_q  <= '0;
            ptr_s2 <= '0;
            ptr_s3 <= '0;
        end else begin
            vld_q  <= {vld_q[1:0], desc_valid};
            adp_q  <= {adp_q[1:0], desc_adaptive};
            drp_q  <= {drp_q[1:0], member_mask == '0};
            ptr_s2 <= ptr_s1;
            ptr_s3 <= ptr_s2;
        end
    end

    // Choose between the tree winner and the hash pick.
    always_comb begin
        sel_valid = vld_q[2];
        sel_drop  = vld_q[2] & drp_q[2];
        if (drp_q[2])
            sel_port = '0;
        else if (adp_q[2])
            sel_port = key_s3[IDX_W-1:0] + ptr_s3;
        else
            sel_port = hash_s3;
    end

    assign unused_load = ^key_s3[KEY_W-2:IDX_W];

    // R9: every descriptor is answered three cycles later.
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        desc_valid |-> ##3 sel_valid);

    // R8: an empty group produces a drop.
    a_r8_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && member_mask == '0) |-> ##3 (sel_valid && sel_drop));

    // R3: any non-drop result names a member of the group.
    a_r3_port_is_member: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !sel_drop) |-> |($past(member_mask, 3) & (NPORTS'(1) << sel_port)));

    // R1: a flagged winner is always a candidate port.
    a_r1_winner_cand: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !sel_drop && adp_q[2]) |-> !key_s3[KEY_W-1]);

endmodule

// File: tb/sim_mpath_egress_sel.sv
// Self-checking bench: a model of the tier, threshold, pointer and hash
// rules predicts each result; a three-deep line of expectations is
// compared at each falling edge before the next descriptor is driven.
module sim_mpath_egress_sel;

    localparam int NP = 16;
    localparam int NC = 8;
    localparam int OW = 16;
    localparam int HW = 16;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              desc_valid;
    logic [HW-1:0]     desc_hash;
    logic [2:0]        desc_tc;
    logic              desc_adaptive;
    logic [NP-1:0]     member_mask;
    logic [NP-1:0]     short_tag;
    logic [OW-1:0]     cong_thresh;
    logic [NP*NC*OW-1:0] occ_flat;
    logic              sel_valid;
    logic [3:0]        sel_port;
    logic              sel_drop;

    always #4 clk = ~clk;

    mpath_egress_sel u0 (
        .clk(clk), .rst_n(rst_n), .desc_valid(desc_valid), .desc_hash(desc_hash),
        .desc_tc(desc_tc), .desc_adaptive(desc_adaptive), .member_mask(member_mask),
        .short_tag(short_tag), .cong_thresh(cong_thresh), .occ_flat(occ_flat),
        .sel_valid(sel_valid), .sel_port(sel_port), .sel_drop(sel_drop)
    );

    int    n_tests = 0;
    int    n_fail  = 0;
    int    ptr_m   = 0;
    bit    done    = 0;
    logic [OW-1:0] occ_s [NP][NC];
    bit    vh [3];
    bit    ed [3];
    int    ep [3];
    string rq [3];

    task automatic check(bit ok, string r, int act, int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", r, act, expv);
        end
    endtask

    function automatic int exp_adapt(logic [NP-1:0] m, logic [NP-1:0] s,
                                     int thr, int tc, int ptr);
        logic [NP-1:0] ss, ls, cand;
        bit okS, okL;
        int best, bl;
        ss = m & s; ls = m & ~s;
        if (ss == 0) begin ss = m; ls = 0; end
        okS = 0; okL = 0;
        for (int p = 0; p < NP; p++) begin
            if (ss[p] && int'(occ_s[p][tc]) < thr) okS = 1;
            if (ls[p] && int'(occ_s[p][tc]) < thr) okL = 1;
        end
        cand = okS ? ss : (okL ? ls : m);
        best = -1; bl = 0;
        for (int d = 0; d < NP; d++) begin
            int p;
            p = (ptr + d) % NP;
            if (cand[p] && (best < 0 || int'(occ_s[p][tc]) < bl)) begin
                best = p; bl = int'(occ_s[p][tc]);
            end
        end
        return best;
    endfunction

    function automatic int exp_hash(logic [NP-1:0] m, int h);
        int cnt, r, k;
        cnt = $countones(m);
        r = h % cnt;
        k = 0;
        for (int p = 0; p < NP; p++) begin
            if (m[p]) begin
                if (k == r) return p;
                k++;
            end
        end
        return 0;
    endfunction

    // One cycle: check the result due now, then drive the next descriptor.
    task automatic issue(bit v, bit a, int h, int tc, logic [NP-1:0] m,
                         logic [NP-1:0] s, int thr, string r);
        @(negedge clk);
        if (vh[2]) begin
            check(sel_valid == 1'b1, {rq[2], "/R9 valid"}, int'(sel_valid), 1);
            check(sel_drop == ed[2], {rq[2], " drop"}, int'(sel_drop), int'(ed[2]));
            check(int'(sel_port) == ep[2], {rq[2], " port"}, int'(sel_port), ep[2]);
        end else begin
            check(sel_valid == 1'b0, "R9 idle", int'(sel_valid), 0);
        end
        for (int i = 2; i > 0; i--) begin
            vh[i] = vh[i-1]; ed[i] = ed[i-1]; ep[i] = ep[i-1]; rq[i] = rq[i-1];
        end
        desc_valid    = v;
        desc_adaptive = a;
        desc_hash     = HW'(h);
        desc_tc       = 3'(tc);
        member_mask   = m;
        short_tag     = s;
        cong_thresh   = OW'(thr);
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NC; c++)
                occ_flat[((p*NC)+c)*OW +: OW] = occ_s[p][c];
        vh[0] = v; ed[0] = 0; ep[0] = 0; rq[0] = r;
        if (v) begin
            if (m == 0) begin
                ed[0] = 1; ep[0] = 0;
            end else if (a) begin
                ep[0] = exp_adapt(m, s, thr, tc, ptr_m);
                ptr_m = (ptr_m + 1) % NP;
            end else begin
                ep[0] = exp_hash(m, h);
            end
        end
    endtask

    task automatic fill_occ(int lim);
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NC; c++)
                occ_s[p][c] = OW'($urandom % lim);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 0; desc_valid = 0; desc_hash = '0; desc_tc = '0; desc_adaptive = 0;
        member_mask = '0; short_tag = '0; cong_thresh = '0; occ_flat = '0;
        for (int i = 0; i < 3; i++) begin vh[i] = 0; ed[i] = 0; ep[i] = 0; rq[i] = ""; end
        for (int p = 0; p < NP; p++) for (int c = 0; c < NC; c++) occ_s[p][c] = '0;
        repeat (4) @(negedge clk);
        check(sel_valid == 1'b0, "R10 reset", int'(sel_valid), 0);
        rst_n = 1;

        // R7/R10: all loads equal, pointer starts at 0 and wraps.
        for (int i = 0; i < 20; i++)
            issue(1, 1, 0, 1, 16'hFFFF, 16'h0000, 100, "R7");

        // R2: own-class queue light, other classes heavy on the same port.
        for (int p = 0; p < NP; p++)
            for (int c = 0; c < NC; c++)
                occ_s[p][c] = (c == 5) ? 16'd50 : 16'd2;
        for (int c = 0; c < NC; c++) occ_s[3][c] = (c == 5) ? 16'd1 : 16'd900;
        issue(1, 1, 0, 5, 16'hFFFF, 16'h0000, 1000, "R2");
        issue(1, 1, 0, 5, 16'h00F0, 16'h0000, 1000, "R2");

        // R8: empty mask, flagged and unflagged; pointer must not move.
        issue(1, 1, 7, 0, 16'h0000, 16'h0000, 5, "R8");
        issue(1, 0, 7, 0, 16'h0000, 16'h0000, 5, "R8");
        for (int p = 0; p < NP; p++) for (int c = 0; c < NC; c++) occ_s[p][c] = 16'd4;
        issue(1, 1, 0, 0, 16'hFFFF, 16'h0000, 9, "R8 pointer");

        // R3: fixed hash under changing occupancy, then a hash sweep.
        for (int i = 0; i < 10; i++) begin
            fill_occ(50);
            issue(1, 0, 1234, i % NC, 16'hA612, 16'h0F0F, 20, "R3");
        end
        for (int h = 0; h < 40; h++)
            issue(1, 0, h, 0, 16'hA612, 16'h0000, 0, "R3");

        // R4/R5/R6: ports 0-3 shortest, 4-7 longer, threshold 10, class 2.
        fill_occ(1000);
        occ_s[0][2] = 7;  occ_s[1][2] = 4;  occ_s[2][2] = 9;  occ_s[3][2] = 5;
        occ_s[4][2] = 1;  occ_s[5][2] = 1;  occ_s[6][2] = 1;  occ_s[7][2] = 1;
        issue(1, 1, 0, 2, 16'h00FF, 16'h000F, 10, "R4");
        occ_s[0][2] = 12; occ_s[1][2] = 10; occ_s[2][2] = 15; occ_s[3][2] = 11;
        occ_s[4][2] = 9;  occ_s[5][2] = 3;  occ_s[6][2] = 20; occ_s[7][2] = 3;
        issue(1, 1, 0, 2, 16'h00FF, 16'h000F, 10, "R5");
        issue(1, 1, 0, 2, 16'h00FF, 16'h000F, 10, "R5");
        occ_s[4][2] = 30; occ_s[5][2] = 10; occ_s[6][2] = 20; occ_s[7][2] = 40;
        issue(1, 1, 0, 2, 16'h00FF, 16'h000F, 10, "R6");
        issue(1, 1, 0, 2, 16'h00FF, 16'h000F, 10, "R6");
        issue(1, 1, 0, 2, 16'h00FF, 16'h00FF, 10, "R6");

        // R1: single-member groups pick that member.
        for (int p = 0; p < NP; p++) begin
            fill_occ(100);
            issue(1, 1, 0, p % NC, NP'(1) << p, 16'h0000, 50, "R1");
        end

        // Random sweep with small loads (many ties) and random gaps.
        for (int i = 0; i < 3000; i++) begin
            logic [NP-1:0] m, s;
            bit v, a;
            string tag;
            fill_occ(6);
            m = NP'($urandom);
            if ($urandom % 8 == 0) m = '0;
            case ($urandom % 3)
                0:       s = '0;
                1:       s = NP'($urandom);
                default: s = m;
            endcase
            v = ($urandom % 4) != 0;
            a = ($urandom % 3) != 0;
            tag = !a ? "R3" : (s == '0 ? "R1" : "R5");
            issue(v, a, int'($urandom % 65536), int'($urandom % NC), m, s,
                  int'($urandom % 7), tag);
        end

        for (int i = 0; i < 4; i++)
            issue(0, 0, 0, 0, '0, '0, 0, "R9");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule